// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog timer that software controls through a small 32-bit register port. Software writes 16-bit key codes to a key register to start the watchdog, to refresh its down-counter, and to open or close write access to two configuration registers. The configuration registers hold a prescaler code and a 12-bit reload value. When the counter runs out, the block raises a reset request that the system reset controller consumes.

The counter runs from a slow, independent counter clock of roughly 32 kHz. Inside the block this clock appears as a single-cycle strobe, `slow_tick`, sampled on the bus clock. A new prescaler or reload value crosses into the counter domain after a fixed number of counter-clock ticks. Until then a per-field busy flag stays set. Software polls the status register until both flags read zero, then refreshes the counter so that the new values apply.

Register offsets, in bytes: 0x00 key, 0x04 prescaler code, 0x08 reload value, 0x0C status, 0x10 window. The window register is reserved and reads zero. The register port has no data stream, so no valid/ready handshake applies. A write is a single-cycle `wr_en` strobe. Reads are combinational on `addr`.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `reset_req` is 0, status reads 0, the prescaler register reads 0 and the reload register reads 0xFFF. The watchdog is stopped and write access is closed.
- R2: The counter does not count until key 0xCCCC has been written to offset 0x00 (key in bits [15:0]; bits [31:16] are ignored). While stopped, `reset_req` never asserts.
- R3: Key 0xAAAA loads the down-counter with the active reload value and restarts the prescaler phase. Refreshing before expiry keeps `reset_req` low.
- R4: Key 0x5555 opens write access. Any other key value closes it. A write to offset 0x04 or 0x08 while access is closed leaves the register's read-back value unchanged.
- R5: Prescaler code n (bits [2:0] of offset 0x04) divides the counter clock by 4·2^n for n = 0..6. Code 7 divides by 256.
- R6: The reload register keeps only bits [11:0] of the written data. The maximum value is 0xFFF.
- R7: Status bit 0 is set by an accepted prescaler write, and status bit 1 by an accepted reload write. Each flag clears on the third counter-clock tick after the write. At that point the new value becomes the active one. A further accepted write restarts that count.
- R8: Once started, the counter steps down once per prescaler period. After a refresh with reload R ≥ 1 and division D, `reset_req` rises on tick R·D and stays high until the next tick. The counter then holds at zero. Further keys give no second pulse until the block is reset.
- R9: Once started, no register write stops the watchdog. Writing key 0x0000 or any other value still lets the count expire.
- R10: Reads of offsets 0x00 and 0x10 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe marking each edge of the slow counter clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| reset_req | output | 1 | Reset request, high for one counter-clock period on expiry |

## Verification
Most wrong internal states in this block reach the ports only through `reset_req` timing, and often only much later. A prescaler that divides wrongly, or a counter loaded with the wrong value, moves the expiry edge by whole prescaler periods, which can be hundreds of ticks after the fault. A lock flag stuck open shows up at once, because the prescaler and reload registers read back the new value. A sync count that is one tick off shows within three ticks as a busy flag clearing early or late. A reference model therefore compares the read port and `reset_req` on every clock. Directed checks also look at the expiry edge for several divisions.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int KEY_W = 16;

  localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;

  localparam logic [4:0] OFF_KEY    = 5'h00;
  localparam logic [4:0] OFF_PRESC  = 5'h04;
  localparam logic [4:0] OFF_RELOAD = 5'h08;
  localparam logic [4:0] OFF_STATUS = 5'h0C;

  typedef struct packed {
    logic start;
    logic refresh;
    logic unlock;
  } key_cmd_t;
endpackage

// File: rtl/kwd_sync_field.sv
module kwd_sync_field #(
  parameter int W          = 12,
  parameter logic [W-1:0] RESET_VAL = '0,
  parameter int SYNC_TICKS = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         busy
);
  localparam int SW = $clog2(SYNC_TICKS + 1);
  localparam logic [SW-1:0] SYNC_INIT = SW'(SYNC_TICKS);

  logic [SW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= RESET_VAL;
      active <= RESET_VAL;
      busy   <= 1'b0;
      left_q <= '0;
    end else if (load) begin
      shadow <= din;
      busy   <= 1'b1;
      left_q <= SYNC_INIT;
    end else if (busy && tick) begin
      if (left_q == SW'(1)) begin
        active <= shadow;
        busy   <= 1'b0;
        left_q <= '0;
      end else begin
        left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/kwd_regfile.sv
module kwd_regfile
  import kwd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter int PRE_W      = 3,
  parameter int RELOAD_W   = 12,
  parameter int SYNC_TICKS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  output logic                started,
  output logic                refresh,
  output logic                unlocked,
  output logic [PRE_W-1:0]    pre_shadow,
  output logic [PRE_W-1:0]    pre_active,
  output logic [RELOAD_W-1:0] rel_active,
  output logic                pre_busy,
  output logic                rel_busy
);
  localparam logic [RELOAD_W-1:0] RELOAD_MAX = '1;

  logic [RELOAD_W-1:0] rel_shadow;
  logic                key_wr, pre_load, rel_load;
  key_cmd_t            cmd;

  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:KEY_W];

  assign key_wr      = wr_en && (addr == ADDR_W'(OFF_KEY));
  assign cmd.start   = key_wr && (wr_data[KEY_W-1:0] == KEY_START);
  assign cmd.refresh = key_wr && (wr_data[KEY_W-1:0] == KEY_REFRESH);
  assign cmd.unlock  = key_wr && (wr_data[KEY_W-1:0] == KEY_UNLOCK);
  assign refresh     = cmd.refresh;
  assign pre_load    = wr_en && unlocked && (addr == ADDR_W'(OFF_PRESC));
  assign rel_load    = wr_en && unlocked && (addr == ADDR_W'(OFF_RELOAD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started  <= 1'b0;
      unlocked <= 1'b0;
    end else begin
      if (cmd.start) started <= 1'b1;
      if (key_wr) unlocked <= cmd.unlock;
    end
  end

  kwd_sync_field #(.W(PRE_W), .RESET_VAL('0), .SYNC_TICKS(SYNC_TICKS)) u_pre_sync (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(pre_load),
    .din(wr_data[PRE_W-1:0]), .shadow(pre_shadow), .active(pre_active), .busy(pre_busy)
  );

  kwd_sync_field #(.W(RELOAD_W), .RESET_VAL(RELOAD_MAX), .SYNC_TICKS(SYNC_TICKS)) u_rel_sync (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(rel_load),
    .din(wr_data[RELOAD_W-1:0]), .shadow(rel_shadow), .active(rel_active), .busy(rel_busy)
  );

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(OFF_PRESC))       rd_data = DATA_W'(pre_shadow);
    else if (addr == ADDR_W'(OFF_RELOAD)) rd_data = DATA_W'(rel_shadow);
    else if (addr == ADDR_W'(OFF_STATUS)) rd_data = DATA_W'({rel_busy, pre_busy});
  end
endmodule

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
  parameter int PRE_W    = 3,
  parameter int LOG_BASE = 2,
  parameter int LOG_MAX  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] code,
  output logic             step
);
  localparam int CNT_W = LOG_MAX;
  localparam int LOG_W = $clog2(LOG_MAX + 1) + 1;

  logic [CNT_W-1:0] phase_q, last;
  logic [LOG_W-1:0] div_log;
  logic [CNT_W:0]   span;

  always_comb begin
    if (LOG_W'(code) + LOG_W'(LOG_BASE) > LOG_W'(LOG_MAX)) div_log = LOG_W'(LOG_MAX);
    else div_log = LOG_W'(code) + LOG_W'(LOG_BASE);
    span = (CNT_W+1)'(1) << div_log;
    last = CNT_W'(span - 1'b1);
  end

  assign step = run && tick && !restart && (phase_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else if (!run || restart) phase_q <= '0;
    else if (tick) phase_q <= (phase_q == last) ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int RELOAD_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                step,
  input  logic                refresh,
  input  logic [RELOAD_W-1:0] reload_val,
  output logic [RELOAD_W-1:0] count,
  output logic                expired,
  output logic                reset_req
);
  localparam logic [RELOAD_W-1:0] RELOAD_MAX = '1;

  logic [RELOAD_W-1:0] next_cnt;
  logic                hit;

  assign next_cnt = (count == '0) ? '0 : count - 1'b1;
  assign hit      = !expired && !refresh && step && (next_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= RELOAD_MAX;
      expired   <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      if (!expired) begin
        if (refresh) count <= reload_val;
        else if (step) count <= next_cnt;
      end
      if (hit) expired <= 1'b1;
      if (hit) reset_req <= 1'b1;
      else if (tick) reset_req <= 1'b0;
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter int PRE_W      = 3,
  parameter int RELOAD_W   = 12,
  parameter int SYNC_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              reset_req
);
  logic                started, refresh, unlocked, pre_busy, rel_busy, step, expired;
  logic [PRE_W-1:0]    pre_shadow, pre_active;
  logic [RELOAD_W-1:0] rel_active, count;

  kwd_regfile #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRE_W(PRE_W),
    .RELOAD_W(RELOAD_W), .SYNC_TICKS(SYNC_TICKS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .started(started), .refresh(refresh),
    .unlocked(unlocked), .pre_shadow(pre_shadow), .pre_active(pre_active),
    .rel_active(rel_active), .pre_busy(pre_busy), .rel_busy(rel_busy)
  );

  kwd_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .run(started),
    .restart(refresh), .code(pre_active), .step(step)
  );

  kwd_counter #(.RELOAD_W(RELOAD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .step(step), .refresh(refresh),
    .reload_val(rel_active), .count(count), .expired(expired), .reset_req(reset_req)
  );
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
  parameter int ADDR_W   = 5,
  parameter int PRE_W    = 3,
  parameter int RELOAD_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                slow_tick,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   addr,
  input logic                reset_req,
  input logic                started,
  input logic                refresh,
  input logic                unlocked,
  input logic                pre_busy,
  input logic [PRE_W-1:0]    pre_shadow,
  input logic [RELOAD_W-1:0] count,
  input logic                expired
);
  logic fired_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fired_q <= 1'b0;
    else if (reset_req) fired_q <= 1'b1;
  end

  AST_PULSE_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req && slow_tick |=> !reset_req); // R8
  AST_SINGLE_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> !fired_q); // R8
  AST_EXPIRED_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> count == '0); // R8
  AST_IDLE_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !started && !refresh |=> $stable(count)); // R2
  AST_LOCKED_PRESC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == ADDR_W'(5'h04) && !unlocked |=> $stable(pre_shadow)); // R4
  AST_BUSY_CLEARS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pre_busy) |-> $past(slow_tick)); // R7
endmodule

bind keyed_watchdog kwd_checker #(.ADDR_W(ADDR_W), .PRE_W(PRE_W), .RELOAD_W(RELOAD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en), .addr(addr),
  .reset_req(reset_req), .started(started), .refresh(refresh), .unlocked(unlocked),
  .pre_busy(pre_busy), .pre_shadow(pre_shadow), .count(count), .expired(expired)
);

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, b_tick = 1'b0, b_wr = 1'b0;
  logic [4:0]  b_addr = 5'h0C;
  logic [31:0] b_data = '0;
  logic [31:0] rd_data;
  logic        reset_req;

  int checks = 0, errors = 0, rises = 0, tick_div = 1, tcnt = 0, cycles = 0;
  logic prev_rr = 1'b0;

  // behavioural reference state
  int m_started, m_unlock, m_psh, m_pact, m_pb, m_ps, m_rsh, m_ract, m_rb, m_rs;
  int m_phase, m_cnt, m_exp, m_rr;

  keyed_watchdog uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(b_tick), .wr_en(b_wr), .addr(b_addr),
    .wr_data(b_data), .rd_data(rd_data), .reset_req(reset_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    tcnt++;
    b_tick = (tcnt % tick_div) == 0;
  end

  function automatic int m_read(int a);
    if (a == 4) return m_psh;
    if (a == 8) return m_rsh;
    if (a == 12) return m_rb * 2 + m_pb;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_started = 0; m_unlock = 0; m_psh = 0; m_pact = 0; m_pb = 0; m_ps = 0;
      m_rsh = 4095; m_ract = 4095; m_rb = 0; m_rs = 0;
      m_phase = 0; m_cnt = 4095; m_exp = 0; m_rr = 0;
    end else begin
      int kv, dlog, div, nxt;
      bit keyw, rl, step, evt;
      kv   = b_data[15:0];
      keyw = b_wr && b_addr == 0;
      rl   = keyw && kv == 16'hAAAA;
      dlog = (m_pact + 2 > 8) ? 8 : m_pact + 2;
      div  = 1 << dlog;
      step = m_started != 0 && b_tick && !rl && m_phase == div - 1;
      nxt  = (m_cnt == 0) ? 0 : m_cnt - 1;
      evt  = m_exp == 0 && !rl && step && nxt == 0;
      if (m_started == 0 || rl) m_phase = 0;
      else if (b_tick) m_phase = (m_phase == div - 1) ? 0 : m_phase + 1;
      if (m_exp == 0) begin
        if (rl) m_cnt = m_ract;
        else if (step) m_cnt = nxt;
      end
      if (evt) begin m_exp = 1; m_rr = 1; end
      else if (b_tick) m_rr = 0;
      if (b_wr && b_addr == 4 && m_unlock != 0) begin
        m_psh = b_data[2:0]; m_pb = 1; m_ps = 3;
      end else if (m_pb != 0 && b_tick) begin
        if (m_ps == 1) begin m_pact = m_psh; m_pb = 0; m_ps = 0; end
        else m_ps--;
      end
      if (b_wr && b_addr == 8 && m_unlock != 0) begin
        m_rsh = b_data[11:0]; m_rb = 1; m_rs = 3;
      end else if (m_rb != 0 && b_tick) begin
        if (m_rs == 1) begin m_ract = m_rsh; m_rb = 0; m_rs = 0; end
        else m_rs--;
      end
      if (keyw && kv == 16'hCCCC) m_started = 1;
      if (keyw) m_unlock = (kv == 16'h5555) ? 1 : 0;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (reset_req !== (m_rr != 0)) begin
        errors++;
        $display("FAIL R8 reset_req actual=%0b expected=%0b", reset_req, m_rr);
      end
      checks++;
      if (rd_data !== 32'(m_read(int'(b_addr)))) begin
        errors++;
        $display("FAIL R7 rd_data@%0h actual=%0h expected=%0h", b_addr, rd_data, m_read(int'(b_addr)));
      end
      if (reset_req && !prev_rr) rises++;
    end
    prev_rr = reset_req;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    b_wr = 1'b1; b_addr = a; b_data = d;
    @(posedge clk); #1;
    b_wr = 1'b0; b_addr = 5'h0C;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    b_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rises = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(5'h04, v); chk("R1 prescaler reset", v, 32'h0);
    rd(5'h08, v); chk("R1 reload reset", v, 32'hFFF);
    rd(5'h0C, v); chk("R1 status reset", v, 32'h0);
    chk("R1 reset_req reset", {31'b0, reset_req}, 32'h0);

    wr(5'h04, 32'h3);
    rd(5'h04, v); chk("R4 locked prescaler write ignored", v, 32'h0);
    wr(5'h00, 32'h5555);
    wr(5'h04, 32'h7);
    rd(5'h04, v); chk("R4 unlocked prescaler write", v, 32'h7);
    rd(5'h0C, v); chk("R7 prescaler busy set", v, 32'h1);
    repeat (10) @(posedge clk);
    rd(5'h0C, v); chk("R7 prescaler busy cleared", v, 32'h0);
    wr(5'h08, 32'h1005);
    rd(5'h08, v); chk("R6 reload keeps 12 bits", v, 32'h005);
    wr(5'h00, 32'h1234);
    wr(5'h08, 32'h0AA);
    rd(5'h08, v); chk("R4 other key relocks", v, 32'h005);
    wr(5'h00, 32'h5555);
    wr(5'h04, 32'h0);
    repeat (10) @(posedge clk);
    rd(5'h0C, v); chk("R7 both flags clear", v, 32'h0);
    rd(5'h00, v); chk("R10 key offset reads zero", v, 32'h0);
    rd(5'h10, v); chk("R10 window offset reads zero", v, 32'h0);

    wr(5'h00, 32'hAAAA);
    repeat (100) @(posedge clk);
    chk("R2 no expiry before start", rises, 0);

    wr(5'h00, 32'hCCCC);
    wr(5'h00, 32'hAAAA);
    for (int i = 0; i < 6; i++) begin
      repeat (12) @(posedge clk);
      wr(5'h00, 32'hAAAA);
    end
    chk("R3 refresh keeps reset_req low", rises, 0);
    wr(5'h00, 32'h0000);
    wr(5'h04, 32'h6);
    repeat (40) @(posedge clk);
    chk("R9 zero key cannot stop", rises, 1);
    wr(5'h00, 32'hAAAA);
    repeat (100) @(posedge clk);
    chk("R8 no second pulse after expiry", rises, 1);

    tick_div = 2;
    do_reset();
    wr(5'h00, 32'h5555);
    wr(5'h04, 32'h7);
    wr(5'h08, 32'h1);
    repeat (20) @(posedge clk);
    wr(5'h00, 32'hCCCC);
    wr(5'h00, 32'hAAAA);
    repeat (480) @(posedge clk);
    chk("R5 code 7 not yet expired", rises, 0);
    repeat (80) @(posedge clk);
    chk("R5 code 7 divides by 256", rises, 1);

    do_reset();
    wr(5'h00, 32'h5555);
    wr(5'h04, 32'h2);
    wr(5'h08, 32'h2);
    repeat (20) @(posedge clk);
    wr(5'h00, 32'hCCCC);
    wr(5'h00, 32'hAAAA);
    repeat (56) @(posedge clk);
    chk("R5 code 2 not yet expired", rises, 0);
    repeat (20) @(posedge clk);
    chk("R5 code 2 divides by 16", rises, 1);
    repeat (10) @(posedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule